// File: doc/BRIEF.md
# Reference Divider with Tap Select

This block sits in the reference path of a dual-loop frequency synthesizer. It produces the comparison pulses for two phase detectors. A programmable pre-divider counts reference clock cycles and emits one terminal pulse every R cycles. A binary post-counter, clocked by those terminal pulses, derives slower streams at 2R, 4R, 8R and 16R. That gives five candidate pulse streams in total.

Two independent selects each pick one of the five streams. One select feeds the main loop's detector and the other feeds the auxiliary loop's detector, so the two loops may compare at different rates. The whole block runs on the reference clock. Every counter is synchronous and gated by an enable. A power-down input holds every counter at zero. Releasing it restarts the count from a known phase, so the reference side lines up with a main divider that restarts at the same moment.

The outputs are plain single-cycle pulses and have no flow control. Nothing downstream can refuse a reference edge, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `refdiv_tapsel`

## Requirements
- R1: For a ratio input between 4 and 1023, select code 0 gives one output pulse every R reference clock cycles.
- R2: A ratio input of 0, 1, 2 or 3 divides exactly as a ratio of 4 does.
- R3: Select codes 1, 2, 3 and 4 give one pulse every 2R, 4R, 8R and 16R cycles respectively, so code k gives a period of 2^k·R.
- R4: Select codes 5, 6 and 7 produce exactly the same pulse train as code 4.
- R5: The main and auxiliary outputs follow their own select inputs independently of each other. When the two selects are equal, the two outputs are identical.
- R6: Every output pulse is exactly one clock cycle high. The pulses of a slower tap coincide with pulses of every faster tap, all aligned to the pre-divider's terminal count.
- R7: While the power-down input is high, both outputs stay low and all counters are held at zero. After it falls, the output for code k first goes high in the cycle that follows the 2^k·R-th rising clock edge after the release, counting the first edge with power-down low as edge 1. Pulses then repeat at that period.
- R8: While reset (active low, asynchronous) is asserted, both outputs are low. Leaving reset with power-down low gives the same phase as a power-down release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ratio | input | 10 | Pre-divider ratio R; values below 4 act as 4 |
| main_tap_sel | input | 3 | Tap code for the main detector (0..4, above 4 acts as 4) |
| aux_tap_sel | input | 3 | Tap code for the auxiliary detector (0..4, above 4 acts as 4) |
| pwr_dn | input | 1 | High holds all counters at zero and silences the outputs |
| main_cmp_pulse | output | 1 | Single-cycle comparison pulse for the main loop |
| aux_cmp_pulse | output | 1 | Single-cycle comparison pulse for the auxiliary loop |

## Verification
The hardest condition to reach from the ports is the slowest tap at the largest ratio. Its first pulse only appears 16·1023 edges after a release, and the phase of all five taps must still be exact after a power-down that cuts a period short. The bench sweeps every select code on both outputs across a set of small ratios, including the clamped ones. It enters power-down between configurations, partway through a period, so each run starts from an interrupted phase. It also makes one long run at the maximum ratio with the main output on code 0 and the auxiliary output on code 4. Every cycle is compared against a period computed arithmetically from the ratio and the code.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  // number of selectable comparison streams (pre-divider plus post stages)
  localparam int unsigned TAP_COUNT = 5;
  localparam int unsigned POST_STAGES = TAP_COUNT - 1;

  // saturate a select code onto the last tap
  function automatic int unsigned tap_index(input int unsigned code);
    return (code > POST_STAGES) ? POST_STAGES : code;
  endfunction
endpackage

// File: rtl/refdiv_prescale.sv
module refdiv_prescale #(
  parameter int unsigned RW   = 10,
  parameter int unsigned RMIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] ratio,
  output logic          term
);
  localparam logic [RW-1:0] RMIN_V = RW'(RMIN);

  logic [RW-1:0] cnt;
  logic [RW-1:0] eff;
  logic [RW-1:0] last;

  always_comb begin
    eff  = (ratio < RMIN_V) ? RMIN_V : ratio;
    last = eff - RW'(1);
    // >= keeps a lowered ratio from letting the count run past its end
    term = run && (cnt >= last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (term) cnt <= '0;
    else           cnt <= cnt + RW'(1);
  end

  // R1
  tc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (cnt == '0));

  // R2
  tc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> !term);

  // R7
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/refdiv_post.sv
module refdiv_post #(
  parameter int unsigned STAGES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  output logic [STAGES:0] taps
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (!run)  q <= '0;
    else if (tick)  q <= q + STAGES'(1);
  end

  assign taps[0] = tick;

  genvar gi;
  generate
    for (gi = 1; gi <= STAGES; gi++) begin : g_tap
      // stage gi fires when every lower bit is about to carry
      assign taps[gi] = tick & (&q[gi-1:0]);
    end
  endgenerate

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && taps[STAGES]) |=> (q == '0));

  // R7
  post_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (q == '0));
endmodule

// File: rtl/refdiv_tapmux.sv
module refdiv_tapmux #(
  parameter int unsigned NT = 5,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [SW-1:0] sel,
  input  logic [NT-1:0] taps,
  output logic          pulse
);
  localparam logic [SW-1:0] TOP_CODE = SW'(NT - 1);

  logic [SW-1:0] idx;
  logic          hit;

  always_comb begin
    idx = (sel > TOP_CODE) ? TOP_CODE : sel;
    hit = taps[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= run & hit;
  end

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/refdiv_tapsel.sv
module refdiv_tapsel
  import refdiv_pkg::*;
#(
  parameter int unsigned R_WIDTH   = 10,
  parameter int unsigned R_MIN     = 4,
  parameter int unsigned SEL_WIDTH = 3
) (
  input  logic                 clk_ref,
  input  logic                 rst_n,
  input  logic [R_WIDTH-1:0]   div_ratio,
  input  logic [SEL_WIDTH-1:0] main_tap_sel,
  input  logic [SEL_WIDTH-1:0] aux_tap_sel,
  input  logic                 pwr_dn,
  output logic                 main_cmp_pulse,
  output logic                 aux_cmp_pulse
);
  localparam int unsigned NT = TAP_COUNT;

  logic          run;
  logic          term;
  logic [NT-1:0] taps;
  logic [1:0]    pulses;
  logic [SEL_WIDTH-1:0] sels [2];

  assign run     = ~pwr_dn;
  assign sels[0] = main_tap_sel;
  assign sels[1] = aux_tap_sel;

  refdiv_prescale #(.RW(R_WIDTH), .RMIN(R_MIN)) u_pre (
    .clk(clk_ref), .rst_n(rst_n), .run(run), .ratio(div_ratio), .term(term)
  );

  refdiv_post #(.STAGES(POST_STAGES)) u_post (
    .clk(clk_ref), .rst_n(rst_n), .run(run), .tick(term), .taps(taps)
  );

  genvar gd;
  generate
    for (gd = 0; gd < 2; gd++) begin : g_det
      refdiv_tapmux #(.NT(NT), .SW(SEL_WIDTH)) u_mux (
        .clk(clk_ref), .rst_n(rst_n), .run(run),
        .sel(sels[gd]), .taps(taps), .pulse(pulses[gd])
      );
    end
  endgenerate

  assign main_cmp_pulse = pulses[0];
  assign aux_cmp_pulse  = pulses[1];

  // R7
  pd_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pwr_dn |=> (!main_cmp_pulse && !aux_cmp_pulse));

  // R5
  same_sel_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(main_tap_sel) == $past(aux_tap_sel)) |-> (main_cmp_pulse == aux_cmp_pulse));

  // R8
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!main_cmp_pulse && !aux_cmp_pulse);
    end
  end
endmodule

// File: tb/refdiv_tapsel_tb.sv
module refdiv_tapsel_tb;
  logic       clk_ref = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] div_ratio = 10'd5;
  logic [2:0] main_tap_sel = 3'd0;
  logic [2:0] aux_tap_sel = 3'd0;
  logic       pwr_dn = 1'b0;
  logic       main_cmp_pulse;
  logic       aux_cmp_pulse;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_ref = ~clk_ref;

  refdiv_tapsel u_dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .div_ratio(div_ratio),
    .main_tap_sel(main_tap_sel), .aux_tap_sel(aux_tap_sel), .pwr_dn(pwr_dn),
    .main_cmp_pulse(main_cmp_pulse), .aux_cmp_pulse(aux_cmp_pulse)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int t);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s edge %0d actual %0b expected %0b", req, t, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic int period_of(input int r, input int code);
    int eff = (r < 4) ? 4 : r;
    int k = (code > 4) ? 4 : code;
    return eff << k;
  endfunction

  // compare both outputs each cycle for nedges edges after a start
  task automatic observe(input int r, input int ms, input int as, input int nedges);
    int mp = period_of(r, ms);
    int ap = period_of(r, as);
    int mcount = 0;
    string mreq;
    if (r < 4) mreq = "R2";
    else if (ms > 4) mreq = "R4";
    else if (ms == 0) mreq = "R1";
    else mreq = "R3";
    for (int t = 1; t <= nedges; t++) begin
      @(posedge clk_ref);
      @(negedge clk_ref);
      // R7: first pulse after 2^k*R edges from release
      chk(mreq, main_cmp_pulse, (t % mp) == 0, t);
      chk("R5", aux_cmp_pulse, (t % ap) == 0, t);
      if (main_cmp_pulse) mcount++;
    end
    // R6: single-cycle pulses give exactly one high cycle per period
    chk("R6", mcount == nedges / mp, 1'b1, nedges);
  endtask

  // enter power-down, reconfigure, check silence, release, observe
  task automatic run_cfg(input int r, input int ms, input int as, input int nedges);
    @(negedge clk_ref);
    pwr_dn = 1'b1;
    div_ratio = 10'(r);
    main_tap_sel = 3'(ms);
    aux_tap_sel = 3'(as);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_ref);
      @(negedge clk_ref);
      chk("R7", main_cmp_pulse, 1'b0, i);
      chk("R7", aux_cmp_pulse, 1'b0, i);
    end
    pwr_dn = 1'b0;
    observe(r, ms, as, nedges);
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int rlist[7] = '{0, 1, 3, 4, 5, 6, 9};
    // R8: outputs low during reset
    repeat (3) begin
      @(negedge clk_ref);
      chk("R8", main_cmp_pulse, 1'b0, 0);
      chk("R8", aux_cmp_pulse, 1'b0, 0);
    end
    // R8: leaving reset gives release phase (R=5, codes 0 and 2)
    div_ratio = 10'd5;
    main_tap_sel = 3'd0;
    aux_tap_sel = 3'd2;
    rst_n = 1'b1;
    observe(5, 0, 2, 47);

    // sweep: every code on main, a different code on aux; runs end mid-period
    foreach (rlist[ri]) begin
      for (int ms = 0; ms < 8; ms++) begin
        int as = (ms + 3) % 8;
        int eff = (rlist[ri] < 4) ? 4 : rlist[ri];
        run_cfg(rlist[ri], ms, as, 2 * 16 * eff + 3);
      end
    end
    // R5: equal selects give equal outputs
    run_cfg(7, 2, 2, 70);
    // R1/R3: largest ratio, fastest and slowest taps
    run_cfg(1023, 0, 4, 16 * 1023 + 5);
    // R4: saturated codes at largest ratio
    run_cfg(1023, 7, 4, 16 * 1023 + 2);

    summary();
    $finish;
  end
endmodule